// File: doc/BRIEF.md
# GPIO Port with Filtered Pin-Change Interrupts

This block is a general-purpose I/O port controller for up to 32 pins. A simple synchronous register bus sets up each pin: whether the port drives it, the level it drives, and whether its pull-up is on. The block presents these as three vectors to the pad ring. It samples the pad inputs through a two-flop synchroniser, and software reads the synchronised levels back through a pin-level register.

Each pin can raise a pin-change interrupt. The interrupt path can take an optional per-pin glitch filter, which passes a new level only after two equal consecutive samples. The filter adds two cycles of delay. The readback path never goes through the filter. To save power, a pin's input sampler runs only while the port drives that pin or while its interrupt is enabled. An idle sampler reads as 0.

A write takes effect on the clock edge where `bus_we` is high. Read data is registered: `bus_rdata` shows the register that `bus_addr` selected at the previous edge.

Top module: `gpio_bank`

## Requirements
- R1: Register at address 0 holds one drive-enable bit per pin. `drv_en_o` equals it from the cycle after a write, and a 0 bit deasserts that pin's enable.
- R2: Register at address 1 holds the output level. `out_val_o` follows it from the cycle after a write, and reading address 1 returns it.
- R3: A write to address 2 sets the output-level bits where the data is 1. A write to address 3 clears them where the data is 1. Data bits that are 0 leave bits unchanged. `out_val_o` changes in the same cycle as it does after a direct write to address 1.
- R4: Reading address 7 returns each pad level delayed by two synchroniser flops, whatever drives the pad. A pin whose drive-enable and interrupt-enable bits are both 0 reads 0.
- R5: Register at address 4 holds the pull-up enables. `pull_en_o` follows it whatever the drive-enable bits are.
- R6: With the filter off, a level change on a pin whose interrupt enable (address 6) is 1 sets its flag. `irq_o` rises on the third rising edge after the pad changes.
- R7: With a pin's filter bit (address 5) at 1, the flag rises two edges later than in R6. A pad level held for only one sampling cycle is ignored, and a level held for two cycles is accepted.
- R8: The filter has no effect on pin-level readback. A one-cycle pulse on a filtered pin still appears in the value read from address 7.
- R9: Flags are read at address 8. Writing 1 to a flag bit clears it, and writing 0 has no effect. A new event in the same cycle as its clear keeps the flag set. `irq_o` is the OR of all flags.
- R10: Reset, which is synchronous and active high, clears every register, the flags and all outputs to 0.
- R11: For five cycles after a pin's sampler starts, level changes on that pin set no flag. Enabling an interrupt while the pad is already high therefore raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Registered read data |
| pad_i | input | N | Pad input levels |
| drv_en_o | output | N | Per-pin output enable |
| out_val_o | output | N | Per-pin driven level |
| pull_en_o | output | N | Per-pin pull-up enable |
| irq_o | output | 1 | Pin-change interrupt |

## Verification
The bench goes after the exact latencies, with and without the filter. A design with a missing or extra flop would raise `irq_o` one edge early or late. It sends one-cycle and two-cycle pulses to a filtered pin: a wrong filter would pass the glitch or drop the valid pulse. It also samples the readback during that glitch, which catches a filter placed on the readback path. It checks that an idle pin reads 0 and that enabling an interrupt on a high pad raises nothing. A sampler without gating, or a detector without the settle window, would fail those checks. Set and clear writes are compared against the reference model on every clock, so a clear that hits the zero bits, or an alias one cycle late, shows up as a mismatch on `out_val_o`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DRV  = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PULL = 4'd4;
  localparam logic [ADDR_W-1:0] A_FILT = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_LVL  = 4'd7;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd8;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] active_i,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] lvl_o
);
  logic [N-1:0] s1_q, s2_q;

  // Idle pins hold zeros in both stages (sampler gated off).
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_i & active_i;
      s2_q <= s1_q & active_i;
    end
  end

  assign lvl_o = s2_q;

  // R4: a pin idle for two edges reads zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lvl_o & ~$past(active_i)) == '0));
endmodule

// File: rtl/gpio_bank_filter.sv
module gpio_bank_filter #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] path_o
);
  logic [N-1:0] hist_q, held_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[g] <= 1'b0;
        held_q[g] <= 1'b0;
      end else begin
        hist_q[g] <= din_i[g];
        if (din_i[g] == hist_q[g]) held_q[g] <= din_i[g];
      end
    end
    assign path_o[g] = en_i[g] ? held_q[g] : din_i[g];
  end

  // R7: the held level only moves to a value seen on two consecutive samples
  a_r7_two_samples: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((held_q ^ $past(held_q)) & ($past(din_i) ^ $past(hist_q))) == '0));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int N       = 32,
  parameter int ARM_LEN = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] path_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] active_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  localparam int TOP = ARM_LEN - 1;

  logic [N-1:0] prev_q, flag_q, ready, event_v;
  logic [ARM_LEN-1:0] arm_q [N];

  for (genvar g = 0; g < N; g++) begin : g_arm
    always_ff @(posedge clk) begin
      if (rst || !active_i[g]) arm_q[g] <= '0;
      else                     arm_q[g] <= {arm_q[g][TOP-1:0], 1'b1};
    end
    assign ready[g] = arm_q[g][TOP];
  end

  assign event_v = (path_i ^ prev_q) & ien_i & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= path_i;
      flag_q <= (flag_q & ~clr_i) | event_v;
    end
  end

  assign flag_o = flag_q;

  // R9: cleared bits stay clear unless a new event arrived
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(clr_i) & ~$past(event_v)) == '0));
  // R11: a pin that is not yet settled never gains a flag
  a_r11_settle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ready)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N       = 32,
  parameter int ARM_LEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pad_i,
  output logic [N-1:0]      drv_en_o,
  output logic [N-1:0]      out_val_o,
  output logic [N-1:0]      pull_en_o,
  output logic              irq_o
);
  logic [N-1:0] drv_q, out_q, pull_q, filt_q, ien_q, rd_q;
  logic [N-1:0] active, lvl, path, flag, clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= '0;
      out_q  <= '0;
      pull_q <= '0;
      filt_q <= '0;
      ien_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DRV:   drv_q  <= bus_wdata;
        A_OUT:   out_q  <= bus_wdata;
        A_SET:   out_q  <= out_q | bus_wdata;
        A_CLR:   out_q  <= out_q & ~bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        A_FILT:  filt_q <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign active = drv_q | ien_q;
  assign clr    = (bus_we && bus_addr == A_FLAG) ? bus_wdata : '0;

  gpio_bank_sync #(.N(N)) i_sync (
    .clk(clk), .rst(rst), .active_i(active), .pad_i(pad_i), .lvl_o(lvl));

  gpio_bank_filter #(.N(N)) i_filter (
    .clk(clk), .rst(rst), .en_i(filt_q), .din_i(lvl), .path_o(path));

  gpio_bank_irq #(.N(N), .ARM_LEN(ARM_LEN)) i_irq (
    .clk(clk), .rst(rst), .path_i(path), .ien_i(ien_q), .active_i(active),
    .clr_i(clr), .flag_o(flag));

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (bus_addr)
        A_DRV:   rd_q <= drv_q;
        A_OUT:   rd_q <= out_q;
        A_PULL:  rd_q <= pull_q;
        A_FILT:  rd_q <= filt_q;
        A_IEN:   rd_q <= ien_q;
        A_LVL:   rd_q <= lvl;
        A_FLAG:  rd_q <= flag;
        default: rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_q;
  assign drv_en_o  = drv_q;
  assign out_val_o = out_q;
  assign pull_en_o = pull_q;
  assign irq_o     = |flag;

  // R1: drive enables take the written word on the next cycle
  a_r1_drive_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DRV) |=> (drv_en_o == $past(bus_wdata)));
  // R3: set alias ORs in ones only
  a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET) |=> (out_val_o == ($past(out_val_o) | $past(bus_wdata))));
  // R3: clear alias removes ones only
  a_r3_clr_alias: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR) |=> (out_val_o == ($past(out_val_o) & ~$past(bus_wdata))));
  // R5: pull-ups take the written word regardless of drive enables
  a_r5_pull_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_PULL) |=> (pull_en_o == $past(bus_wdata)));
  // R10: outputs are zero right after reset
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (drv_en_o == '0 && out_val_o == '0 && pull_en_o == '0 && !irq_o));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] drv_en_o, out_val_o, pull_en_o;
  logic irq_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
    .drv_en_o(drv_en_o), .out_val_o(out_val_o), .pull_en_o(pull_en_o),
    .irq_o(irq_o));

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural reference model: pad history per pin, settle counters.
  logic [N-1:0] m_drv, m_out, m_pull, m_filt, m_ien, m_flag, m_rd;
  logic [N-1:0] smp [$];      // synchronised-level history, newest at front
  logic [N-1:0] m_lvl, m_pathprev, m_held;
  int settle [N];

  function automatic logic [N-1:0] stage(input logic [N-1:0] pad, input logic [N-1:0] act);
    return pad & act;
  endfunction

  logic [N-1:0] m_s1;

  always @(posedge clk) begin
    logic [N-1:0] act, path, ev, clr, newlvl, prevlvl;
    if (rst) begin
      m_drv = '0; m_out = '0; m_pull = '0; m_filt = '0; m_ien = '0;
      m_flag = '0; m_rd = '0; m_s1 = '0; m_lvl = '0; m_held = '0;
      m_pathprev = '0;
      smp = {'0, '0};
      for (int i = 0; i < N; i++) settle[i] = 0;
    end else begin
      act = m_drv | m_ien;
      prevlvl = smp[1];
      path = (m_filt & m_held) | (~m_filt & m_lvl);
      ev = '0;
      for (int i = 0; i < N; i++)
        if (path[i] != m_pathprev[i] && m_ien[i] && settle[i] >= 5) ev[i] = 1'b1;
      clr = (bus_we && bus_addr == 4'd8) ? bus_wdata : '0;
      case (bus_addr)
        4'd0: m_rd = m_drv;  4'd1: m_rd = m_out;  4'd4: m_rd = m_pull;
        4'd5: m_rd = m_filt; 4'd6: m_rd = m_ien;  4'd7: m_rd = m_lvl;
        4'd8: m_rd = m_flag; default: m_rd = '0;
      endcase
      // held level: accept the current sample if equal to the previous one
      for (int i = 0; i < N; i++) if (m_lvl[i] == prevlvl[i]) m_held[i] = m_lvl[i];
      m_pathprev = path;
      m_flag = (m_flag & ~clr) | ev;
      for (int i = 0; i < N; i++) settle[i] = act[i] ? (settle[i] < 5 ? settle[i] + 1 : 5) : 0;
      newlvl = stage(m_s1, act);
      m_s1 = stage(pad_i, act);
      smp.push_front(newlvl);
      if (smp.size() > 2) void'(smp.pop_back());
      m_lvl = newlvl;
      if (bus_we) begin
        case (bus_addr)
          4'd0: m_drv = bus_wdata;
          4'd1: m_out = bus_wdata;
          4'd2: m_out = m_out | bus_wdata;
          4'd3: m_out = m_out & ~bus_wdata;
          4'd4: m_pull = bus_wdata;
          4'd5: m_filt = bus_wdata;
          4'd6: m_ien = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 drv_en_o", drv_en_o, m_drv);
      chk("R3 out_val_o", out_val_o, m_out);
      chk("R5 pull_en_o", pull_en_o, m_pull);
      chk("R9 irq_o", N'(irq_o), N'(|m_flag));
      chk("R4 bus_rdata", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [N-1:0] v;

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R10: all outputs clear after reset
    chk("R10 reset drv", drv_en_o, '0);
    chk("R10 reset out", out_val_o, '0);
    chk("R10 reset pull", pull_en_o, '0);
    chk("R10 reset irq", N'(irq_o), '0);

    wr(4'd0, 32'h0000_00F0);
    chk("R1 drive enable", drv_en_o, 32'h0000_00F0);
    wr(4'd1, 32'h0000_00A5);
    chk("R2 output level", out_val_o, 32'h0000_00A5);
    rd(4'd1, v);
    chk("R2 readback", v, 32'h0000_00A5);
    wr(4'd2, 32'h0000_0F00);
    chk("R3 set alias", out_val_o, 32'h0000_0FA5);
    wr(4'd3, 32'h0000_0005);
    chk("R3 clear alias", out_val_o, 32'h0000_0FA0);
    wr(4'd4, 32'h0000_0001);
    chk("R5 pull-up on undriven pin", pull_en_o, 32'h0000_0001);

    pad_i = '1;
    idle(4);
    rd(4'd7, v);
    chk("R4 gated readback", v, 32'h0000_00F0);

    // R11: enable interrupt on bit 8 while the pad is already high
    wr(4'd6, 32'h0000_0100);
    idle(10);
    chk("R11 no flag on enable", N'(irq_o), '0);
    rd(4'd7, v);
    chk("R4 readback after enable", v, 32'h0000_01F0);

    // R6: unfiltered latency, change before edge E0, irq after E2
    @(negedge clk); pad_i[8] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 irq not yet", N'(irq_o), '0);
    @(negedge clk);
    chk("R6 irq raised", N'(irq_o), 1);
    wr(4'd8, '0);
    chk("R9 zero write keeps flag", N'(irq_o), 1);
    wr(4'd8, 32'h0000_0100);
    chk("R9 clear flag", N'(irq_o), 0);

    // R7: filtered latency, two edges more
    wr(4'd5, 32'h0000_0100);
    idle(4);
    @(negedge clk); pad_i[8] = 1'b1;
    idle(4);
    chk("R7 filtered irq not yet", N'(irq_o), '0);
    @(negedge clk);
    chk("R7 filtered irq raised", N'(irq_o), 1);
    wr(4'd8, 32'h0000_0100);
    idle(4);

    // R7/R8: one-cycle glitch is rejected but visible in readback
    @(negedge clk); bus_addr = 4'd7; pad_i[8] = 1'b0;
    @(negedge clk); pad_i[8] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 glitch in readback", N'(bus_rdata[8]), 0);
    @(negedge clk);
    chk("R8 readback restored", N'(bus_rdata[8]), 1);
    idle(8);
    chk("R7 glitch rejected", N'(irq_o), 0);

    // R7: two-cycle pulse accepted
    @(negedge clk); pad_i[8] = 1'b0;
    @(negedge clk); @(negedge clk); pad_i[8] = 1'b1;
    idle(8);
    chk("R7 two-cycle pulse accepted", N'(irq_o), 1);
    wr(4'd8, '1);
    chk("R9 clear all", N'(irq_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule